// File: doc/BRIEF.md
# Right Shift and Rotate Execution Unit

This unit executes the right-shift instruction group of a 16-bit processor. The group covers logical shift, arithmetic shift, rotate through carry, and arithmetic shift with carry out. Each instruction can move the operand by one place or by two. The unit holds four 16-bit working registers and four condition flags: sign, zero, carry and overflow. An accepted instruction reads one register, computes the shifted value and the new flags, and writes them all back on a single clock edge. It then counts off the instruction's execution time and reports its end with a one-cycle done pulse.

Instructions arrive on a valid/ready handshake. An instruction is taken on a rising edge where `exec_valid` and `exec_ready` are both high. After a legal instruction is taken, `exec_ready` stays low until the done pulse, and that stalls the issuer. While `exec_ready` is low, the issuer must hold `exec_valid` and `exec_opcode` steady. A plain load port lets the surrounding logic preset registers and the carry and overflow flags. A combinational read port returns any register.

Top module: `rshift_unit`

## Requirements
- R1: An opcode is in the group when its bits 9:5 equal 5'b00011 (0x060 to 0x07F). Bits 4:3 pick the operation: 00 logical shift, 01 arithmetic shift, 10 rotate through carry, 11 arithmetic shift with carry out. Bits 1:0 name the register that is both source and destination. Bit 2 set means two places and bit 2 clear means one place.
- R2: Logical shift fills each vacated top bit with zero and leaves carry and overflow unchanged.
- R3: Arithmetic shift copies the original bit 15 into the top bit at every step and leaves carry and overflow unchanged.
- R4: Rotate through carry moves the old carry into bit 15 at the first step and loads the new carry from the original bit 0. In the two-place form, the old overflow enters bit 15 at the second step and overflow takes the original bit 1. In the one-place form, overflow is unchanged.
- R5: Arithmetic shift with carry out copies the original bit 15 into the top bit at every step and loads carry from the original bit 0. In the two-place form, overflow takes the original bit 1. In the one-place form, overflow is unchanged.
- R6: After every legal instruction, sign equals bit 7 of the result and zero is set only when all 16 result bits are zero. The register and all four flags change on the acceptance edge.
- R7: `cyc_count` shows 6 after a one-place instruction and 8 after a two-place one, from the acceptance edge until the next accepted instruction.
- R8: `exec_ready` is high when idle. After a legal instruction is accepted, `exec_ready` is low from the next cycle until the done pulse.
- R9: `done` is high for exactly one cycle, starting `cyc_count` cycles after the acceptance edge. `exec_ready` returns in that same cycle, so a new instruction can be accepted on the edge that ends the pulse.
- R10: An accepted opcode outside the group leaves registers and flags unchanged. It pulses `illegal` for one cycle, sets `cyc_count` to 0, produces no done pulse, and keeps `exec_ready` high.
- R11: `ld_en` writes `ld_data` into register `ld_idx`, and `ld_flags_en` writes carry and overflow, both on the clock edge. A load in a cycle where an instruction is accepted is discarded.
- R12: Reset clears all registers and flags, `cyc_count`, `done` and `illegal`, and leaves `exec_ready` high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| exec_valid | input | 1 | Instruction offered |
| exec_ready | output | 1 | Unit can take an instruction |
| exec_opcode | input | 10 | Instruction opcode |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 2 | Register to load |
| ld_data | input | 16 | Load value |
| ld_flags_en | input | 1 | Carry/overflow load strobe |
| ld_c | input | 1 | Carry load value |
| ld_o | input | 1 | Overflow load value |
| rd_idx | input | 2 | Register to read |
| rd_data | output | 16 | Selected register value |
| flag_s | output | 1 | Sign flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_o | output | 1 | Overflow flag |
| cyc_count | output | 4 | Cycle count of the last accepted instruction |
| done | output | 1 | End-of-execution pulse |
| illegal | output | 1 | Out-of-group opcode pulse |

## Verification
Two things can land in the same cycle. The first is the done pulse of one instruction together with the acceptance of the next. The bench keeps `exec_valid` high while the unit is busy, so the second instruction is taken on the edge that ends the pulse. It then checks that `done` falls, `exec_ready` falls and the new result is written. The second is a register or flag load on the very edge that accepts an instruction. The bench offers both in one cycle and checks that the instruction's result and flags survive and the load leaves no trace.

// File: rtl/rshift_pkg.sv
package rshift_pkg;

  typedef enum logic [1:0] {
    OP_LSR  = 2'b00,
    OP_ASR  = 2'b01,
    OP_RRC  = 2'b10,
    OP_SARC = 2'b11
  } rs_op_e;

  typedef struct packed {
    rs_op_e op;
    logic   twice;
    logic   legal;
  } rs_dec_t;

  typedef struct packed {
    logic c;
    logic o;
    logic s;
    logic z;
  } rs_flags_t;

  localparam logic [4:0] GROUP_TAG = 5'b00011;

endpackage

// File: rtl/rshift_decode.sv
module rshift_decode
  import rshift_pkg::*;
#(
  parameter int OPW = 10,
  parameter int IW  = 2
) (
  input  logic [OPW-1:0] opcode,
  output rs_dec_t        dec,
  output logic [IW-1:0]  ridx
);
  localparam int TAGW = OPW - 5;

  always_comb begin
    dec.legal = (opcode[OPW-1:5] == TAGW'(GROUP_TAG));
    dec.op    = rs_op_e'(opcode[4:3]);
    dec.twice = opcode[2];
    ridx      = opcode[IW-1:0];
  end
endmodule

// File: rtl/rshift_datapath.sv
module rshift_datapath
  import rshift_pkg::*;
#(
  parameter int DW       = 16,
  parameter int SIGN_BIT = 7
) (
  input  rs_op_e          op,
  input  logic            twice,
  input  logic [DW-1:0]   val,
  input  rs_flags_t       flags_in,
  output logic [DW-1:0]   res,
  output rs_flags_t       flags_out
);
  logic          fill1, fill2;
  logic [DW-1:0] step1;

  always_comb begin
    unique case (op)
      OP_LSR:  begin fill1 = 1'b0;        fill2 = 1'b0;        end
      OP_RRC:  begin fill1 = flags_in.c;  fill2 = flags_in.o;  end
      default: begin fill1 = val[DW-1];   fill2 = val[DW-1];   end
    endcase
    step1 = {fill1, val[DW-1:1]};
    res   = twice ? {fill2, step1[DW-1:1]} : step1;

    flags_out.c = flags_in.c;
    flags_out.o = flags_in.o;
    if (op == OP_RRC || op == OP_SARC) begin
      flags_out.c = val[0];
      if (twice) flags_out.o = val[1];
    end
    flags_out.s = res[SIGN_BIT];
    flags_out.z = (res == '0);
  end
endmodule

// File: rtl/rshift_regfile.sv
module rshift_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 4,
  localparam int IW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [IW-1:0] widx,
  input  logic [DW-1:0] wdata,
  input  logic [IW-1:0] src_idx,
  output logic [DW-1:0] src_data,
  input  logic [IW-1:0] rd_idx,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    for (int i = 0; i < NREG; i++) begin
      if (!rst_n)                      regs[i] <= '0;
      else if (we && widx == IW'(i))   regs[i] <= wdata;
    end
  end

  assign src_data = regs[src_idx];
  assign rd_data  = regs[rd_idx];
endmodule

// File: rtl/rshift_timer.sv
module rshift_timer #(
  parameter int CYC_SINGLE = 6,
  parameter int CYC_DOUBLE = 8,
  localparam int CW        = $clog2(CYC_DOUBLE + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clr,
  input  logic          twice,
  output logic          idle,
  output logic [CW-1:0] cyc_count,
  output logic          done
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] len;

  assign len  = twice ? CW'(CYC_DOUBLE) : CW'(CYC_SINGLE);
  assign idle = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt       <= '0;
      cyc_count <= '0;
      done      <= 1'b0;
    end else begin
      done <= (cnt == CW'(1));
      if (start) begin
        cnt       <= len;
        cyc_count <= len;
      end else begin
        if (cnt != '0) cnt <= cnt - 1'b1;
        if (clr)       cyc_count <= '0;
      end
    end
  end

  // R9: done lasts one cycle
  a_r9_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8: a new start only arrives while idle
  a_r8_start_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> idle);
endmodule

// File: rtl/rshift_unit.sv
module rshift_unit
  import rshift_pkg::*;
#(
  parameter int DW         = 16,
  parameter int NREG       = 4,
  parameter int OPW        = 10,
  parameter int CYC_SINGLE = 6,
  parameter int CYC_DOUBLE = 8,
  localparam int IW        = $clog2(NREG),
  localparam int CW        = $clog2(CYC_DOUBLE + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           exec_valid,
  output logic           exec_ready,
  input  logic [OPW-1:0] exec_opcode,
  input  logic           ld_en,
  input  logic [IW-1:0]  ld_idx,
  input  logic [DW-1:0]  ld_data,
  input  logic           ld_flags_en,
  input  logic           ld_c,
  input  logic           ld_o,
  input  logic [IW-1:0]  rd_idx,
  output logic [DW-1:0]  rd_data,
  output logic           flag_s,
  output logic           flag_z,
  output logic           flag_c,
  output logic           flag_o,
  output logic [CW-1:0]  cyc_count,
  output logic           done,
  output logic           illegal
);
  rs_dec_t       dec;
  logic [IW-1:0] ridx;
  logic [DW-1:0] src_data, res;
  rs_flags_t     flags_q, flags_nx;
  logic          acc, take, idle;
  logic          we;
  logic [IW-1:0] widx;
  logic [DW-1:0] wdata;

  rshift_decode #(.OPW(OPW), .IW(IW)) u_dec (
    .opcode(exec_opcode), .dec(dec), .ridx(ridx));

  rshift_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(wdata),
    .src_idx(ridx), .src_data(src_data), .rd_idx(rd_idx), .rd_data(rd_data));

  rshift_datapath #(.DW(DW)) u_dp (
    .op(dec.op), .twice(dec.twice), .val(src_data), .flags_in(flags_q),
    .res(res), .flags_out(flags_nx));

  rshift_timer #(.CYC_SINGLE(CYC_SINGLE), .CYC_DOUBLE(CYC_DOUBLE)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(take), .clr(acc && !dec.legal),
    .twice(dec.twice), .idle(idle), .cyc_count(cyc_count), .done(done));

  assign exec_ready = idle;
  assign acc        = exec_valid && exec_ready;
  assign take       = acc && dec.legal;

  // execution write-back wins; a load in an accepting cycle is dropped
  assign we    = take || (ld_en && !acc);
  assign widx  = acc ? ridx : ld_idx;
  assign wdata = acc ? res  : ld_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags_q <= '0;
      illegal <= 1'b0;
    end else begin
      illegal <= acc && !dec.legal;
      if (take) flags_q <= flags_nx;
      else if (!acc && ld_flags_en) begin
        flags_q.c <= ld_c;
        flags_q.o <= ld_o;
      end
    end
  end

  assign flag_s = flags_q.s;
  assign flag_z = flags_q.z;
  assign flag_c = flags_q.c;
  assign flag_o = flags_q.o;

  // R2: logical shift keeps carry and overflow
  a_r2_lsr_keeps_co: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dec.op == OP_LSR) |=> ({flag_c, flag_o} == $past({flag_c, flag_o})));

  // R5: carry-out shift loads carry from source bit 0
  a_r5_sarc_carry: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dec.op == OP_SARC) |=> (flag_c == $past(src_data[0])));

  // R4: single rotate leaves overflow alone
  a_r4_single_keeps_o: assert property (@(posedge clk) disable iff (!rst_n)
    (take && dec.op == OP_RRC && !dec.twice) |=> (flag_o == $past(flag_o)));

  // R8: busy after a legal acceptance
  a_r8_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !exec_ready);

  // R10: out-of-group opcode keeps flags and readiness
  a_r10_illegal_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !dec.legal) |=> ($stable({flag_c, flag_o, flag_s, flag_z}) && exec_ready && illegal));
endmodule

// File: tb/rshift_unit_test.sv
module rshift_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;
  // {opcode, value, c_in, o_in, expected value, c, o, s, z}
  localparam logic [47:0] VEC [NV] = '{
    {10'h060, 16'h8001, 1'b0, 1'b0, 16'h4000, 1'b0, 1'b0, 1'b0, 1'b0},
    {10'h06D, 16'h8004, 1'b1, 1'b0, 16'hE001, 1'b1, 1'b0, 1'b0, 1'b0},
    {10'h072, 16'h0001, 1'b1, 1'b0, 16'h8000, 1'b1, 1'b0, 1'b0, 1'b0},
    {10'h077, 16'h0001, 1'b1, 1'b0, 16'h4000, 1'b1, 1'b0, 1'b0, 1'b0},
    {10'h078, 16'h0100, 1'b1, 1'b1, 16'h0080, 1'b0, 1'b1, 1'b1, 1'b0},
    {10'h07E, 16'h8002, 1'b0, 1'b0, 16'hE000, 1'b0, 1'b1, 1'b0, 1'b0},
    {10'h064, 16'h0003, 1'b1, 1'b1, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1},
    {10'h069, 16'h0101, 1'b0, 1'b1, 16'h0080, 1'b0, 1'b1, 1'b1, 1'b0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic exec_valid = 1'b0, exec_ready;
  logic [9:0] exec_opcode = '0;
  logic ld_en = 1'b0, ld_flags_en = 1'b0, ld_c = 1'b0, ld_o = 1'b0;
  logic [1:0] ld_idx = '0, rd_idx = '0;
  logic [15:0] ld_data = '0, rd_data;
  logic flag_s, flag_z, flag_c, flag_o, done, illegal;
  logic [3:0] cyc_count;
  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rshift_unit uut (
    .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid), .exec_ready(exec_ready),
    .exec_opcode(exec_opcode), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .ld_flags_en(ld_flags_en), .ld_c(ld_c), .ld_o(ld_o), .rd_idx(rd_idx),
    .rd_data(rd_data), .flag_s(flag_s), .flag_z(flag_z), .flag_c(flag_c),
    .flag_o(flag_o), .cyc_count(cyc_count), .done(done), .illegal(illegal));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // returns {result, c, o, s, z}
  function automatic logic [19:0] model(input logic [9:0] opc, input logic [15:0] v,
                                        input logic c, input logic o);
    logic [15:0] r;
    logic nc, no;
    nc = c; no = o;
    case (opc[4:3])
      2'b00: r = v >> (opc[2] ? 2 : 1);
      2'b01, 2'b11: r = opc[2] ? {v[15], v[15], v[15:2]} : {v[15], v[15:1]};
      default: r = opc[2] ? {o, c, v[15:2]} : {c, v[15:1]};
    endcase
    if (opc[4]) begin
      nc = v[0];
      if (opc[2]) no = v[1];
    end
    return {r, nc, no, r[7], (r == 16'h0)};
  endfunction

  function automatic string req_of(input logic [9:0] opc);
    case (opc[4:3])
      2'b00: return "R2";
      2'b01: return "R3";
      2'b10: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic load(input logic [1:0] idx, input logic [15:0] d, input logic c, input logic o);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = d;
    ld_flags_en = 1'b1; ld_c = c; ld_o = o;
    @(negedge clk);
    ld_en = 1'b0; ld_flags_en = 1'b0;
  endtask

  // preload, issue, check write-back, cycle count and done timing
  task automatic run_op(input logic [9:0] opc, input logic [15:0] v, input logic c,
                        input logic o, input logic [19:0] exp);
    int n;
    string rq;
    rq = req_of(opc);
    n = opc[2] ? 8 : 6;
    load(opc[1:0], v, c, o);
    rd_idx = opc[1:0];
    exec_valid = 1'b1; exec_opcode = opc;
    check("R8 ready when idle", exec_ready, 1);
    @(negedge clk);
    exec_valid = 1'b0;
    check({rq, " result"}, rd_data, exp[19:4]);
    check({rq, " carry/overflow"}, {flag_c, flag_o}, exp[3:2]);
    check("R6 sign/zero", {flag_s, flag_z}, exp[1:0]);
    check("R7 cycle count", cyc_count, n);
    check("R8 busy", exec_ready, 0);
    repeat (n - 1) @(negedge clk);
    check("R9 no early done", done, 0);
    @(negedge clk);
    check("R9 done on time", {done, exec_ready}, 2'b11);
    @(negedge clk);
    check("R9 done one cycle", done, 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 15000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    check("R12 ready", exec_ready, 1);
    check("R12 flags", {flag_s, flag_z, flag_c, flag_o}, 0);
    check("R12 outputs", {cyc_count, done, illegal}, 0);
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      #1 check("R12 register", rd_data, 0);
    end

    // table of hand-computed vectors (R1 decode through every entry)
    for (int i = 0; i < NV; i++)
      run_op(VEC[i][47:38], VEC[i][37:22], VEC[i][21], VEC[i][20], VEC[i][19:0]);

    // R1: every opcode in the group, all flag pairs, random operands
    for (int op = 'h060; op <= 'h07F; op++)
      for (int f = 0; f < 4; f++)
        for (int k = 0; k < 2; k++) begin
          logic [15:0] v;
          v = 16'($urandom);
          run_op(10'(op), v, f[1], f[0], model(10'(op), v, f[1], f[0]));
        end

    // R10: out-of-group opcode
    load(2'd1, 16'h1234, 1'b1, 1'b0);
    rd_idx = 2'd1;
    exec_valid = 1'b1; exec_opcode = 10'h081;
    @(negedge clk);
    exec_valid = 1'b0;
    check("R10 register kept", rd_data, 16'h1234);
    check("R10 flags kept", {flag_c, flag_o}, 2'b10);
    check("R10 pulse", {illegal, exec_ready}, 2'b11);
    check("R10 count cleared", cyc_count, 0);
    @(negedge clk);
    check("R10 pulse ends", illegal, 0);
    repeat (8) begin
      @(negedge clk);
      check("R10 no done", done, 0);
    end

    // R11: load colliding with an acceptance is dropped
    load(2'd0, 16'h0008, 1'b0, 1'b0);
    rd_idx = 2'd0;
    exec_valid = 1'b1; exec_opcode = 10'h060;
    ld_en = 1'b1; ld_idx = 2'd0; ld_data = 16'hFFFF;
    ld_flags_en = 1'b1; ld_c = 1'b1; ld_o = 1'b1;
    @(negedge clk);
    exec_valid = 1'b0; ld_en = 1'b0; ld_flags_en = 1'b0;
    check("R11 collision result", rd_data, 16'h0004);
    check("R11 collision flags", {flag_c, flag_o}, 2'b00);
    repeat (6) @(negedge clk);
    check("R9 done after collision", done, 1);
    @(negedge clk);

    // R11: plain load while idle
    load(2'd3, 16'hBEEF, 1'b1, 1'b1);
    rd_idx = 2'd3;
    #1 check("R11 load register", rd_data, 16'hBEEF);
    check("R11 load flags", {flag_c, flag_o}, 2'b11);

    // R9: done and next acceptance in the same cycle
    load(2'd0, 16'h00F0, 1'b0, 1'b0);
    rd_idx = 2'd0;
    exec_valid = 1'b1; exec_opcode = 10'h060;
    @(negedge clk);
    exec_opcode = 10'h06C;
    repeat (5) @(negedge clk);
    check("R8 stalled", exec_ready, 0);
    @(negedge clk);
    check("R9 done with pending", {done, exec_ready}, 2'b11);
    @(negedge clk);
    exec_valid = 1'b0;
    check("R9 back-to-back accepted", {done, exec_ready}, 2'b00);
    check("R3 back-to-back result", rd_data, 16'h001E);
    check("R7 back-to-back count", cyc_count, 8);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule